// File: doc/BRIEF.md
# Interrupt Line Enable, Pending and Priority Register Bank

This block holds the per-line interrupt state that a downstream priority arbiter consumes: one enable bit, one pending bit and one 8-bit priority byte for each external interrupt line. Software reaches this state through a simple word-wide register port. Enables and pendings each have two windows, one where writing 1 sets a bit and one where writing 1 clears it, so a single line can change without a read-modify-write. A trigger register pends one line, selected by its number.

The hardware inputs are level signals. A rising edge on a line latches its pending bit, and the bit stays set until software clears it or the arbiter acknowledges the line. The bank drives two things to the arbiter: the vector of lines that are both enabled and pending, and all of the priority bytes, packed flat. Local line 0 corresponds to global exception number 16. That offset belongs to the numbering scheme only and takes no hardware here.

Top module: `irq_bank`

## Requirements
- R1: The register address is 8 bits. Bits [7:5] select a region and bits [4:0] select a word within it. The regions are: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 priority, 5 trigger. In regions 0 to 3, line k sits in word k/32 at bit k mod 32. Regions 6 and 7, and words or bits with no line behind them, read as 0 and ignore writes.
- R2: Writing a 1 to a bit in the set-enable region enables that line. Bits written as 0 leave their lines unchanged.
- R3: Writing a 1 to a bit in the clear-enable region disables that line. Bits written as 0 leave their lines unchanged.
- R4: A read of either the set-enable region or the clear-enable region returns the current enable bits. Read data appears on regRdata in the cycle after the read strobe and holds until the next read.
- R5: Writing a 1 to a bit in the set-pending region pends that line. Writing a 1 in the clear-pending region discards that line's request. A read of either pending region returns the pending bits.
- R6: A pending bit is kept while its line is disabled. irqActive[k] is 1 exactly when line k is both enabled and pending, so a retained request reaches the arbiter as soon as its line is enabled.
- R7: Line k's priority byte is byte lane k mod 4 (bits 8*(k mod 4)+7 down to 8*(k mod 4)) of priority word k/4. It can be read back and drives irqPrio[8k+7:8k].
- R8: A 0-to-1 change on irqIn[k] sets pending bit k in the next cycle. Holding the input high does not pend the line again after it has been cleared.
- R9: A write to the trigger region pends the line numbered by wdata[LINE_W-1:0], where LINE_W = clog2(NUM_LINES). Higher data bits are ignored. A number of NUM_LINES or more has no effect.
- R10: An ackValid pulse clears the pending bit of line ackLine. An ackLine of NUM_LINES or more has no effect.
- R11: When a set (a set-pending write, a trigger or an input edge) and a clear (a clear-pending write or an acknowledge) reach the same pending bit in one cycle, the clear wins. An input edge lost this way pends the line one cycle later.
- R12: Reset clears everything to zero: every enable, every pending bit, every priority byte, and regRdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Write strobe for one word |
| regRdEn | input | 1 | Read strobe |
| regAddr | input | 8 | Region and word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| irqIn | input | NUM_LINES | Level interrupt inputs |
| ackValid | input | 1 | Acknowledge from the arbiter |
| ackLine | input | LINE_W | Line being acknowledged |
| irqActive | output | NUM_LINES | Enabled and pending lines |
| irqPrio | output | 8*NUM_LINES | Priority bytes, line k in bits 8k+7:8k |

## Verification
The bench builds the bank with NUM_LINES = 40. That gives a second enable word with only eight live bits, so writes of all ones into its dead bits show up as ignored on read-back. It also leaves the last priority word full at lines 36 to 39, and it makes trigger and acknowledge numbers from 40 to 63 encodable but out of range. Random writes, reads, input toggles and acknowledges run against a bench model. Directed cases cover clear-versus-set collisions and an input edge lost to a clear, which is expected to return one cycle late.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int ADDR_W   = 8;
  localparam int REGION_W = 3;
  localparam int IDX_W    = ADDR_W - REGION_W;

  typedef enum logic [REGION_W-1:0] {
    RG_SET_EN = 3'd0,
    RG_CLR_EN = 3'd1,
    RG_SET_PD = 3'd2,
    RG_CLR_PD = 3'd3,
    RG_PRIO   = 3'd4,
    RG_TRIG   = 3'd5,
    RG_RSV6   = 3'd6,
    RG_RSV7   = 3'd7
  } regionT;

  // Strobes handed from the decoder to the storage datapath.
  typedef struct packed {
    logic             setEnWr;
    logic             clrEnWr;
    logic             setPdWr;
    logic             clrPdWr;
    logic             prioWr;
    logic             trigWr;
    logic             rdEn;
    regionT           rdRegion;
    logic [IDX_W-1:0] wordIdx;
  } strobeT;
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobeT            str
);
  regionT region;

  assign region = regionT'(regAddr[ADDR_W-1 -: REGION_W]);

  always_comb begin
    str          = '0;
    str.rdEn     = regRdEn;
    str.rdRegion = region;
    str.wordIdx  = regAddr[IDX_W-1:0];
    if (regWrEn) begin
      unique case (region)
        RG_SET_EN: str.setEnWr = 1'b1;
        RG_CLR_EN: str.clrEnWr = 1'b1;
        RG_SET_PD: str.setPdWr = 1'b1;
        RG_CLR_PD: str.clrPdWr = 1'b1;
        RG_PRIO:   str.prioWr  = 1'b1;
        RG_TRIG:   str.trigWr  = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 str,
  input  logic [31:0]            wdata,
  input  logic [NUM_LINES-1:0]   irqIn,
  input  logic                   ackValid,
  input  logic [LINE_W-1:0]      ackLine,
  output logic [31:0]            rdata,
  output logic [NUM_LINES-1:0]   irqActive,
  output logic [8*NUM_LINES-1:0] irqPrio
);
  localparam logic [LINE_W:0] LINES_V = NUM_LINES[LINE_W:0];

  logic [NUM_LINES-1:0] enQ, pendQ, deferQ, irqPrevQ;
  logic [NUM_LINES-1:0] setEnMask, clrEnMask, setPdMask, clrPdMask;
  logic [NUM_LINES-1:0] trigMask, ackMask, edgeVec, pendSetAll, pendClrAll;
  logic [7:0]           prioQ [NUM_LINES];
  logic [LINE_W-1:0]    trigLine;
  logic                 trigInRange;
  logic                 ackInRange;
  logic [31:0]          rdWord;

  assign trigLine    = wdata[LINE_W-1:0];
  assign trigInRange = str.trigWr && ({1'b0, trigLine} < LINES_V);
  assign ackInRange  = ackValid && ({1'b0, ackLine} < LINES_V);

  // Per-line decode of every write window, plus priority storage.
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    localparam int WRD  = k / 32;
    localparam int BIT  = k % 32;
    localparam int PWRD = k / 4;
    localparam int LANE = k % 4;

    assign setEnMask[k] = str.setEnWr && (int'(str.wordIdx) == WRD) && wdata[BIT];
    assign clrEnMask[k] = str.clrEnWr && (int'(str.wordIdx) == WRD) && wdata[BIT];
    assign setPdMask[k] = str.setPdWr && (int'(str.wordIdx) == WRD) && wdata[BIT];
    assign clrPdMask[k] = str.clrPdWr && (int'(str.wordIdx) == WRD) && wdata[BIT];
    assign trigMask[k]  = trigInRange && (trigLine == LINE_W'(k));
    assign ackMask[k]   = ackInRange && (ackLine == LINE_W'(k));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        prioQ[k] <= '0;
      else if (str.prioWr && (int'(str.wordIdx) == PWRD))
        prioQ[k] <= wdata[8*LANE +: 8];
    end

    assign irqPrio[8*k +: 8] = prioQ[k];
  end

  assign edgeVec    = irqIn & ~irqPrevQ;
  assign pendClrAll = clrPdMask | ackMask;
  assign pendSetAll = setPdMask | trigMask | edgeVec | deferQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= '0;
      pendQ    <= '0;
      deferQ   <= '0;
      irqPrevQ <= '0;
    end else begin
      enQ      <= (enQ | setEnMask) & ~clrEnMask;
      pendQ    <= (pendQ | pendSetAll) & ~pendClrAll;
      deferQ   <= edgeVec & pendClrAll;
      irqPrevQ <= irqIn;
    end
  end

  always_comb begin
    rdWord = '0;
    case (str.rdRegion)
      RG_SET_EN, RG_CLR_EN: begin
        for (int k = 0; k < NUM_LINES; k++)
          if (int'(str.wordIdx) == k / 32) rdWord[k % 32] = enQ[k];
      end
      RG_SET_PD, RG_CLR_PD: begin
        for (int k = 0; k < NUM_LINES; k++)
          if (int'(str.wordIdx) == k / 32) rdWord[k % 32] = pendQ[k];
      end
      RG_PRIO: begin
        for (int k = 0; k < NUM_LINES; k++)
          if (int'(str.wordIdx) == k / 4) rdWord[8*(k % 4) +: 8] = prioQ[k];
      end
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdata <= '0;
    else if (str.rdEn) rdata <= rdWord;
  end

  assign irqActive = enQ & pendQ;

  // R2: a set-enable write leaves every targeted line enabled
  a_r2_set_en_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (|setEnMask) |=> ((enQ & $past(setEnMask)) == $past(setEnMask)));

  // R3: a clear-enable write leaves every targeted line disabled
  a_r3_clr_en_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (|clrEnMask) |=> ((enQ & $past(clrEnMask)) == '0));

  // R6: a pending bit is only lost through a clear or an acknowledge
  a_r6_pend_retained: assert property (@(posedge clk) disable iff (!rstN)
    (|pendQ) |=> ((($past(pendQ) & ~$past(pendClrAll)) & ~pendQ) == '0));

  // R8: an input edge that meets no clear is pending in the next cycle
  a_r8_edge_pends: assert property (@(posedge clk) disable iff (!rstN)
    (|(edgeVec & ~pendClrAll)) |=>
      ((pendQ & $past(edgeVec & ~pendClrAll)) == $past(edgeVec & ~pendClrAll)));

  // R9: a trigger write selects at most one line
  a_r9_trig_single: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trigMask));

  // R11: a clear beats any set that lands on the same bit
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|pendClrAll) |=> ((pendQ & $past(pendClrAll)) == '0));
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  input  logic [NUM_LINES-1:0]   irqIn,
  input  logic                   ackValid,
  input  logic [LINE_W-1:0]      ackLine,
  output logic [NUM_LINES-1:0]   irqActive,
  output logic [8*NUM_LINES-1:0] irqPrio
);
  strobeT str;

  irq_bank_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .str     (str)
  );

  irq_bank_dp #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .wdata     (regWdata),
    .irqIn     (irqIn),
    .ackValid  (ackValid),
    .ackLine   (ackLine),
    .rdata     (regRdata),
    .irqActive (irqActive),
    .irqPrio   (irqPrio)
  );
endmodule

// File: tb/irq_bank_tb_top.sv
module irq_bank_tb_top;
  localparam int N  = 40;
  localparam int LW = $clog2(N);

  logic           clk = 1'b0;
  logic           rstN;
  logic           regWrEn, regRdEn, ackValid;
  logic [7:0]     regAddr;
  logic [31:0]    regWdata, regRdata;
  logic [N-1:0]   irqIn, irqActive;
  logic [LW-1:0]  ackLine;
  logic [8*N-1:0] irqPrio;

  always #5 clk = ~clk;

  irq_bank #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqIn(irqIn), .ackValid(ackValid), .ackLine(ackLine),
    .irqActive(irqActive), .irqPrio(irqPrio)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // Bench model, built from the requirements
  logic [N-1:0] mEn, mPend, mDefer, mPrev, curIrq;
  logic [7:0]   mPrio [N];
  logic [31:0]  mRd;

  function automatic logic [7:0] addrOf(int rg, int ix);
    return {rg[2:0], ix[4:0]};
  endfunction

  function automatic logic [31:0] modelRead(int rg, int ix);
    logic [31:0] w = '0;
    for (int k = 0; k < N; k++) begin
      if ((rg == 0 || rg == 1) && ix == k / 32) w[k % 32] = mEn[k];
      if ((rg == 2 || rg == 3) && ix == k / 32) w[k % 32] = mPend[k];
      if (rg == 4 && ix == k / 4) w[8*(k % 4) +: 8] = mPrio[k];
    end
    return w;
  endfunction

  function automatic logic [8*N-1:0] modelPrio();
    logic [8*N-1:0] p;
    for (int k = 0; k < N; k++) p[8*k +: 8] = mPrio[k];
    return p;
  endfunction

  task automatic chk(string tag, string what, logic [8*N-1:0] act, logic [8*N-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic wr, logic rd, logic [7:0] addr, logic [31:0] wd,
                      logic [N-1:0] irq, logic av, logic [LW-1:0] al);
    int rg = int'(addr[7:5]);
    int ix = int'(addr[4:0]);
    logic [N-1:0] sEn = '0, cEn = '0, sP = '0, cP = '0, tr = '0, ak = '0, ed;
    regWrEn = wr; regRdEn = rd; regAddr = addr; regWdata = wd;
    irqIn = irq; ackValid = av; ackLine = al; curIrq = irq;
    if (rd) mRd = modelRead(rg, ix);
    for (int k = 0; k < N; k++) begin
      if (wr && ix == k / 32 && wd[k % 32]) begin
        if (rg == 0) sEn[k] = 1'b1;
        if (rg == 1) cEn[k] = 1'b1;
        if (rg == 2) sP[k]  = 1'b1;
        if (rg == 3) cP[k]  = 1'b1;
      end
    end
    if (wr && rg == 5 && int'(wd[LW-1:0]) < N) tr[wd[LW-1:0]] = 1'b1;
    if (av && int'(al) < N) ak[al] = 1'b1;
    ed = irq & ~mPrev;
    @(posedge clk);
    mPend  = (mPend | sP | tr | ed | mDefer) & ~(cP | ak);
    mDefer = ed & (cP | ak);
    mEn    = (mEn | sEn) & ~cEn;
    mPrev  = irq;
    if (wr && rg == 4)
      for (int k = 0; k < N; k++) if (ix == k / 4) mPrio[k] = wd[8*(k % 4) +: 8];
    @(negedge clk);
    chk(tag, "regRdata", {{(8*N-32){1'b0}}, regRdata}, {{(8*N-32){1'b0}}, mRd});
    chk(tag, "irqActive", {{(7*N){1'b0}}, irqActive}, {{(7*N){1'b0}}, mEn & mPend});
    chk(tag, "irqPrio", irqPrio, modelPrio());
  endtask

  task automatic wrReg(string tag, int rg, int ix, logic [31:0] d);
    step(tag, 1'b1, 1'b0, addrOf(rg, ix), d, curIrq, 1'b0, '0);
  endtask

  task automatic rdReg(string tag, int rg, int ix);
    step(tag, 1'b0, 1'b1, addrOf(rg, ix), '0, curIrq, 1'b0, '0);
  endtask

  task automatic idle(string tag, logic [N-1:0] irq);
    step(tag, 1'b0, 1'b0, '0, '0, irq, 1'b0, '0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    mEn = '0; mPend = '0; mDefer = '0; mPrev = '0; curIrq = '0; mRd = '0;
    for (int k = 0; k < N; k++) mPrio[k] = '0;
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; regAddr = '0; regWdata = '0;
    irqIn = '0; ackValid = 0; ackLine = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R12", "reset irqActive", {{(7*N){1'b0}}, irqActive}, '0);
    chk("R12", "reset irqPrio", irqPrio, '0);
    chk("R12", "reset regRdata", {{(8*N-32){1'b0}}, regRdata}, '0);
    rdReg("R12", 0, 0); rdReg("R12", 2, 1); rdReg("R12", 4, 9);

    // R2 / R4: set-enable, readable through both enable windows
    wrReg("R2", 0, 0, 32'h0000_0005);
    rdReg("R4", 0, 0);
    chk("R4", "set-enable literal", {{(8*N-32){1'b0}}, regRdata}, {{(8*N-32){1'b0}}, 32'h5});
    rdReg("R4", 1, 0);
    // R3: clear-enable, zero bits ignored
    wrReg("R3", 1, 0, 32'h0000_0001);
    rdReg("R3", 1, 0);
    chk("R3", "clear-enable literal", {{(8*N-32){1'b0}}, regRdata}, {{(8*N-32){1'b0}}, 32'h4});
    // R1: dead bits of word 1 and reserved regions
    wrReg("R1", 0, 1, 32'hFFFF_FFFF);
    rdReg("R1", 0, 1);
    chk("R1", "partial word", {{(8*N-32){1'b0}}, regRdata}, {{(8*N-32){1'b0}}, 32'hFF});
    wrReg("R1", 6, 0, 32'hFFFF_FFFF);
    rdReg("R1", 6, 0);
    rdReg("R1", 0, 2);
    wrReg("R3", 1, 1, 32'hFFFF_FFFF);

    // R5 / R6: pend while disabled, then enable
    wrReg("R5", 2, 1, 32'h0000_0002);
    rdReg("R5", 3, 1);
    chk("R6", "disabled line inactive", {{(7*N){1'b0}}, irqActive}, '0);
    wrReg("R6", 0, 1, 32'h0000_0002);
    chk("R6", "line 33 active", {{(7*N){1'b0}}, irqActive}, {{(7*N){1'b0}}, N'(1) << 33});
    wrReg("R5", 3, 1, 32'h0000_0002);
    rdReg("R5", 2, 1);

    // R7: priority lanes
    wrReg("R7", 4, 9, 32'hE0A0_6020);
    rdReg("R7", 4, 9);
    chk("R7", "line 38 byte", {{(8*N-8){1'b0}}, irqPrio[8*38 +: 8]}, {{(8*N-8){1'b0}}, 8'hA0});
    wrReg("R7", 4, 0, 32'h1122_3344);
    rdReg("R7", 4, 10);

    // R8: edge pends, held level does not re-pend
    idle("R8", N'(1) << 10);
    rdReg("R8", 2, 0);
    wrReg("R8", 3, 0, 32'h0000_0400);
    idle("R8", N'(1) << 10);
    rdReg("R8", 2, 0);
    chk("R8", "held level no re-pend", {{(8*N-32){1'b0}}, regRdata}, '0);
    idle("R8", '0);

    // R9: trigger in and out of range
    wrReg("R9", 5, 0, 32'd39);
    wrReg("R9", 5, 0, 32'd40);
    wrReg("R9", 5, 0, 32'd63);
    wrReg("R9", 5, 0, 32'h0000_0105);
    rdReg("R9", 2, 1);
    rdReg("R9", 2, 0);
    chk("R9", "line 5 pended", {{(8*N-32){1'b0}}, regRdata}, {{(8*N-32){1'b0}}, 32'h20});

    // R10: acknowledge
    step("R10", 1'b0, 1'b0, '0, '0, curIrq, 1'b1, LW'(5));
    step("R10", 1'b0, 1'b0, '0, '0, curIrq, 1'b1, LW'(50));
    rdReg("R10", 2, 0);
    rdReg("R10", 2, 1);

    // R11: set-pending and acknowledge collide; edge lost to a clear returns late
    step("R11", 1'b1, 1'b0, addrOf(2, 0), 32'h8, curIrq, 1'b1, LW'(3));
    rdReg("R11", 2, 0);
    step("R11", 1'b1, 1'b0, addrOf(3, 0), 32'h80, N'(1) << 7, 1'b0, '0);
    rdReg("R11", 2, 0);
    chk("R11", "not yet re-pended", {{(8*N-32){1'b0}}, regRdata}, '0);
    rdReg("R11", 2, 0);
    chk("R11", "re-pended one cycle late", {{(8*N-32){1'b0}}, regRdata}, {{(8*N-32){1'b0}}, 32'h80});
    idle("R11", '0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      int rg = $urandom_range(0, 7);
      int ix = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 31) : $urandom_range(0, 3);
      logic [31:0] d = $urandom();
      if (op < 4) begin
        string t;
        case (rg)
          0: t = "R2"; 1: t = "R3"; 2: t = "R5"; 3: t = "R5";
          4: t = "R7"; 5: t = "R9"; default: t = "R1";
        endcase
        if (rg == 4) ix = $urandom_range(0, 11);
        if (rg == 5) d = {$urandom_range(0, 3) == 0 ? d[31:8] : 24'h0, 8'($urandom_range(0, 70))};
        step(t, 1'b1, 1'b0, addrOf(rg, ix), d, curIrq, 1'b0, '0);
      end else if (op < 7) begin
        step("R4", 1'b0, 1'b1, addrOf(rg, rg == 4 ? $urandom_range(0, 11) : ix), '0, curIrq, 1'b0, '0);
      end else if (op < 9) begin
        logic [N-1:0] flip = '0;
        flip[$urandom_range(0, N-1)] = 1'b1;
        step("R8", 1'b0, 1'b0, '0, '0, curIrq ^ flip, 1'b0, '0);
      end else begin
        step("R10", $urandom_range(0, 1) == 1, 1'b1, addrOf(rg, ix), d, curIrq,
             1'b1, LW'($urandom_range(0, 63)));
      end
    end
    summary();
  end
endmodule